// File: doc/BRIEF.md
# Serial Conversion Result Transmitter

This block sends the most recently latched converter result out on one serial data line, framed by a sync pulse and followed by a few user tag bits taken from a tag input. The bit clock comes from one of two sources. In internal-clock mode the block divides its system clock, drives that bit clock out, and enables the shared clock pin as an output. In external-clock mode the pin is an input: the incoming clock is resynchronized into the system clock domain, and only its edges advance the frame.

A frame opens with the sync output high for one bit period while the data line stays low. Each later qualified falling bit-clock edge then puts one result bit on the line, most significant first. After the result bits, each falling edge samples the tag input and forwards it. One more falling edge closes the frame and returns the line to low. In internal-clock mode a frame starts when a new result is reported latched. In external-clock mode it starts when the read enable, meaning chip select low and read/convert high, becomes true. While the parallel/serial select asks for parallel output, the serial function is silent.

Top module: `adc_ser_tx`

## Requirements
- R1: While par_mode_i is 1, sdata_o, sync_o, sclk_o and sclk_oe_o are 0 from the next cycle on. A frame in progress is abandoned and does not resume. No start request is accepted.
- R2: sclk_oe_o is 1 exactly when par_mode_i is 0 and ext_clk_sel_i is 0. When ext_clk_sel_i is 1, sclk_o stays 0 and bit-clock edges are taken from sclk_i.
- R3: In internal-clock mode, sclk_o is low while idle. During a frame it toggles every HALF_DIV system clocks, and its first toggle is a rise HALF_DIV cycles after the start edge.
- R4: In external-clock mode a frame starts on the rising edge of the condition (cs_ni==0 and rc_i==1). This covers rc_i rising with cs_ni low and cs_ni falling with rc_i high. res_load_i has no effect in this mode.
- R5: result_i is captured at the start edge. The frame sends that captured value MSB first, whatever result_i does later.
- R6: sync_o goes high on the start edge and stays high until the first qualified falling bit-clock edge. sdata_o is 0 during that period.
- R7: sdata_o changes only on qualified falling bit-clock edges. A falling edge qualifies only if a rising edge has been seen since the previous qualified falling edge or since the start.
- R8: After the RES_W result bits, each of the next TAG_W qualified falling edges samples tag_i and drives the sampled value on sdata_o.
- R9: The qualified falling edge after the last tag bit ends the frame. sdata_o returns to 0, and in internal-clock mode sclk_o stays low.
- R10: Start requests arriving while a frame is in progress are ignored. The frame continues unchanged.
- R11: In external-clock mode, a falling edge on sclk_i takes effect on the outputs at the SYNC_STAGES+1-th system clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_mode_i | input | 1 | 1 selects parallel output and silences the serial function |
| ext_clk_sel_i | input | 1 | 0 selects the internal bit clock, 1 selects the external bit clock |
| cs_ni | input | 1 | Chip select, active low |
| rc_i | input | 1 | Read/convert strobe, high for read |
| res_load_i | input | 1 | One-cycle pulse when a new result has been latched |
| result_i | input | RES_W | Latched conversion result |
| tag_i | input | 1 | Tag serial input, forwarded after the result bits |
| sclk_i | input | 1 | External bit clock, read from the shared pin |
| sclk_o | output | 1 | Internal bit clock driven to the shared pin |
| sclk_oe_o | output | 1 | Output enable for the shared clock pin |
| sdata_o | output | 1 | Serial data |
| sync_o | output | 1 | Frame sync |

## Verification
The bench builds the block with RES_W 12, TAG_W 3, HALF_DIV 3 and SYNC_STAGES 2. A short divider gives an internal bit period of six system clocks, so many complete frames fit in a short run, and every toggle interval of sclk_o can be measured against HALF_DIV. The two-stage synchronizer fixes the external edge latency at three cycles, which the bench checks at the first falling edge. The three tag bits are enough to show that a fresh tag value is picked up at every falling edge and that the frame ends exactly after the last one.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SYNC = 2'd1,
    PH_DATA = 2'd2,
    PH_TAG  = 2'd3
  } ser_phase_e;
endpackage

// File: rtl/adc_ser_edge_sync.sv
module adc_ser_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              level;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign level = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= level;
  end

  assign rise_o = level & ~last_q;
  assign fall_o = ~level & last_q;
endmodule

// File: rtl/adc_ser_int_clk.sv
module adc_ser_int_clk #(
  parameter int HALF_DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = $clog2(HALF_DIV + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sclk_q;
  logic             tick;

  assign tick = en_i && (cnt_q == CNT_W'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = tick & ~sclk_q;
  assign fall_o = tick & sclk_q;
endmodule

// File: rtl/adc_ser_frame.sv
module adc_ser_frame
  import adc_ser_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int TAG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic             mode_ext_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             tag_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             active_o,
  output logic             mode_ext_o,
  output logic             sdata_o,
  output logic             sync_o
);
  localparam int MAX_W = (RES_W > TAG_W) ? RES_W : TAG_W;
  localparam int CNT_W = $clog2(MAX_W + 1);

  ser_phase_e       phase_q;
  logic [RES_W-1:0] shreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             mode_q;
  logic             sdata_q;
  logic             sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      mode_q  <= 1'b0;
      sdata_q <= 1'b0;
      sync_q  <= 1'b0;
    end else if (abort_i) begin
      phase_q <= PH_IDLE;
      armed_q <= 1'b0;
      sdata_q <= 1'b0;
      sync_q  <= 1'b0;
    end else if (phase_q == PH_IDLE) begin
      if (start_i) begin
        phase_q <= PH_SYNC;
        shreg_q <= result_i;
        mode_q  <= mode_ext_i;
        armed_q <= 1'b0;
        sync_q  <= 1'b1;
        sdata_q <= 1'b0;
      end
    end else begin
      if (rise_i) armed_q <= 1'b1;
      if (fall_i && armed_q) begin
        armed_q <= 1'b0;
        case (phase_q)
          PH_SYNC: begin
            sync_q  <= 1'b0;
            sdata_q <= shreg_q[RES_W-1];
            shreg_q <= shreg_q << 1;
            cnt_q   <= CNT_W'(RES_W - 1);
            phase_q <= PH_DATA;
          end
          PH_DATA: begin
            if (cnt_q != '0) begin
              sdata_q <= shreg_q[RES_W-1];
              shreg_q <= shreg_q << 1;
              cnt_q   <= cnt_q - CNT_W'(1);
            end else begin
              // result done: chain tag input behind it
              sdata_q <= tag_i;
              cnt_q   <= CNT_W'(TAG_W - 1);
              phase_q <= PH_TAG;
            end
          end
          PH_TAG: begin
            if (cnt_q != '0) begin
              sdata_q <= tag_i;
              cnt_q   <= cnt_q - CNT_W'(1);
            end else begin
              sdata_q <= 1'b0;
              phase_q <= PH_IDLE;
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign active_o   = (phase_q != PH_IDLE);
  assign mode_ext_o = mode_q;
  assign sdata_o    = sdata_q;
  assign sync_o     = sync_q;
endmodule

// File: rtl/adc_ser_tx.sv
module adc_ser_tx #(
  parameter int RES_W       = 12,
  parameter int TAG_W       = 3,
  parameter int HALF_DIV    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             par_mode_i,
  input  logic             ext_clk_sel_i,
  input  logic             cs_ni,
  input  logic             rc_i,
  input  logic             res_load_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             tag_i,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             sclk_oe_o,
  output logic             sdata_o,
  output logic             sync_o
);
  logic serial_on;
  logic rd_en_q;
  logic rd_en;
  logic rd_rise;
  logic start;
  logic active;
  logic mode_ext;
  logic int_en;
  logic int_sclk, int_rise, int_fall;
  logic ext_rise, ext_fall;
  logic bit_rise, bit_fall;

  assign serial_on = ~par_mode_i;
  assign rd_en     = ~cs_ni & rc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_en_q <= 1'b0;
    else         rd_en_q <= rd_en;
  end

  assign rd_rise = rd_en & ~rd_en_q;
  assign start   = serial_on & (ext_clk_sel_i ? rd_rise : res_load_i);
  assign int_en  = serial_on & active & ~mode_ext;

  adc_ser_int_clk #(
    .HALF_DIV(HALF_DIV)
  ) u_int_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (int_en),
    .sclk_o (int_sclk),
    .rise_o (int_rise),
    .fall_o (int_fall)
  );

  adc_ser_edge_sync #(
    .STAGES(SYNC_STAGES)
  ) u_ext_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sclk_i),
    .rise_o (ext_rise),
    .fall_o (ext_fall)
  );

  assign bit_rise = mode_ext ? ext_rise : int_rise;
  assign bit_fall = mode_ext ? ext_fall : int_fall;

  adc_ser_frame #(
    .RES_W(RES_W),
    .TAG_W(TAG_W)
  ) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .abort_i    (par_mode_i),
    .start_i    (start),
    .mode_ext_i (ext_clk_sel_i),
    .result_i   (result_i),
    .tag_i      (tag_i),
    .rise_i     (bit_rise),
    .fall_i     (bit_fall),
    .active_o   (active),
    .mode_ext_o (mode_ext),
    .sdata_o    (sdata_o),
    .sync_o     (sync_o)
  );

  assign sclk_oe_o = serial_on & ~ext_clk_sel_i;
  assign sclk_o    = sclk_oe_o & int_sclk;
endmodule

// File: rtl/adc_ser_tx_chk.sv
module adc_ser_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic par_mode_i,
  input logic ext_clk_sel_i,
  input logic sclk_o,
  input logic sclk_oe_o,
  input logic sdata_o,
  input logic sync_o
);
  AST_PAR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_mode_i |=> (!sync_o && !sdata_o)); // R1

  AST_PAR_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_mode_i |-> (!sclk_oe_o && !sclk_o)); // R1

  AST_EXT_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_clk_sel_i |-> !sclk_o); // R2

  AST_SYNC_DATA_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> !sdata_o); // R6

  AST_DATA_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_oe_o && $past(sclk_oe_o) && $changed(sdata_o)) |-> $fell(sclk_o)); // R7
endmodule

bind adc_ser_tx adc_ser_tx_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .par_mode_i    (par_mode_i),
  .ext_clk_sel_i (ext_clk_sel_i),
  .sclk_o        (sclk_o),
  .sclk_oe_o     (sclk_oe_o),
  .sdata_o       (sdata_o),
  .sync_o        (sync_o)
);

// File: tb/tb_adc_ser_tx.sv
module tb_adc_ser_tx;
  localparam int CLK_P       = 10;
  localparam int RES_W       = 12;
  localparam int TAG_W       = 3;
  localparam int HALF_DIV    = 3;
  localparam int SYNC_STAGES = 2;
  localparam int EXT_HALF    = 5;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             par_mode_i = 1'b0;
  logic             ext_clk_sel_i = 1'b0;
  logic             cs_ni = 1'b1;
  logic             rc_i = 1'b0;
  logic             res_load_i = 1'b0;
  logic [RES_W-1:0] result_i = '0;
  logic             tag_i = 1'b0;
  logic             sclk_i = 1'b0;
  logic             sclk_o, sclk_oe_o, sdata_o, sync_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_ser_tx #(
    .RES_W(RES_W), .TAG_W(TAG_W), .HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .par_mode_i(par_mode_i), .ext_clk_sel_i(ext_clk_sel_i),
    .cs_ni(cs_ni), .rc_i(rc_i), .res_load_i(res_load_i), .result_i(result_i),
    .tag_i(tag_i), .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o),
    .sdata_o(sdata_o), .sync_o(sync_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // result bit seen after the k-th data falling edge (k = 1..RES_W)
  function automatic logic exp_bit(input logic [RES_W-1:0] v, input int k);
    return v[RES_W-k];
  endfunction

  task automatic int_frame(input logic [RES_W-1:0] val, input bit disturb);
    logic [TAG_W-1:0] tagv = '0;
    int rises = 0;
    int since = 0;
    logic prev;
    result_i   = val;
    res_load_i = 1'b1;
    tick();
    res_load_i = 1'b0;
    result_i   = RES_W'($urandom);
    prev = sclk_o;
    while (rises < 1 + RES_W + TAG_W) begin
      tick();
      res_load_i = 1'b0;
      since++;
      if (sclk_o != prev) begin
        chk(since == HALF_DIV, "R3 toggle interval", since, HALF_DIV);
        since = 0;
        if (sclk_o) begin
          if (rises == 0)
            chk(sync_o && !sdata_o, "R6 sync period", {sync_o, sdata_o}, 2'b10);
          else if (rises <= RES_W)
            chk(sdata_o == exp_bit(val, rises), "R5 result bit", sdata_o, exp_bit(val, rises));
          else
            chk(sdata_o == tagv[rises-RES_W-1], "R8 tag bit", sdata_o, tagv[rises-RES_W-1]);
          if (rises >= RES_W && rises < RES_W + TAG_W) begin
            tag_i = 1'($urandom);
            tagv[rises-RES_W] = tag_i;
          end
          if (disturb && rises == 4) res_load_i = 1'b1; // R10
          rises++;
        end
        prev = sclk_o;
      end
    end
    tick(HALF_DIV + 1);
    chk(!sdata_o && !sync_o, "R9 frame end", {sync_o, sdata_o}, 0);
    for (int i = 0; i < 2 * HALF_DIV; i++) begin
      tick();
      chk(!sclk_o, "R9 clock stays low", sclk_o, 0);
    end
  endtask

  task automatic ext_frame(input logic [RES_W-1:0] val, input bit cs_path, input bit disturb);
    logic tg;
    sclk_i = 1'b0;
    if (cs_path) begin
      rc_i = 1'b1; tick();
      cs_ni = 1'b0; result_i = val;
    end else begin
      cs_ni = 1'b0; rc_i = 1'b0; tick();
      rc_i = 1'b1; result_i = val;
    end
    tick();
    result_i = RES_W'($urandom);
    tick(2);
    chk(sync_o && !sdata_o, "R4 start", {sync_o, sdata_o}, 2'b10);
    for (int k = 1; k <= RES_W + TAG_W + 1; k++) begin
      sclk_i = 1'b1;
      tg = 1'($urandom);
      tag_i = tg;
      if (disturb && k == 5) begin
        tick(); rc_i = 1'b0; tick(); rc_i = 1'b1; tick(EXT_HALF - 2); // R10
      end else begin
        tick(EXT_HALF);
      end
      sclk_i = 1'b0;
      if (k == 1) begin
        tick(SYNC_STAGES);
        chk(sync_o, "R11 before latency", sync_o, 1);
        tick();
        chk(!sync_o, "R11 after latency", sync_o, 0);
        tick(EXT_HALF - SYNC_STAGES - 1);
      end else begin
        tick(EXT_HALF);
      end
      if (k <= RES_W)
        chk(sdata_o == exp_bit(val, k), "R7 ext result bit", sdata_o, exp_bit(val, k));
      else if (k <= RES_W + TAG_W)
        chk(sdata_o == tg, "R8 ext tag bit", sdata_o, tg);
      else
        chk(!sdata_o && !sync_o, "R9 ext frame end", {sync_o, sdata_o}, 0);
    end
    rc_i = 1'b0; cs_ni = 1'b1;
    tick(2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1234_5eed));
    tick(4);
    rst_ni = 1'b1;
    tick(2);
    chk(!sdata_o && !sync_o && !sclk_o, "R1 reset state", {sync_o, sdata_o, sclk_o}, 0);
    chk(sclk_oe_o, "R2 internal mode drives pin", sclk_oe_o, 1);

    int_frame(12'hA55, 1'b0);
    int_frame(12'hFFF, 1'b0);
    int_frame(12'h000, 1'b1);
    for (int i = 0; i < 4; i++) int_frame(RES_W'($urandom), 1'b0);

    // parallel mode silences and aborts
    result_i = 12'h3C3; res_load_i = 1'b1; tick(); res_load_i = 1'b0;
    tick(8);
    par_mode_i = 1'b1;
    tick(2);
    chk(!sdata_o && !sync_o && !sclk_o && !sclk_oe_o, "R1 parallel quiet",
        {sync_o, sdata_o, sclk_o, sclk_oe_o}, 0);
    res_load_i = 1'b1; tick(); res_load_i = 1'b0; tick(5);
    chk(!sync_o, "R1 no start in parallel", sync_o, 0);
    par_mode_i = 1'b0;
    tick(10);
    chk(!sync_o && !sclk_o && !sdata_o, "R1 no resume", {sync_o, sclk_o, sdata_o}, 0);
    int_frame(12'h5A5, 1'b0);

    // external clock mode
    ext_clk_sel_i = 1'b1;
    tick();
    chk(!sclk_oe_o && !sclk_o, "R2 external mode releases pin", {sclk_oe_o, sclk_o}, 0);
    res_load_i = 1'b1; tick(); res_load_i = 1'b0; tick(20);
    chk(!sync_o, "R4 load ignored in external mode", sync_o, 0);
    ext_frame(12'h801, 1'b0, 1'b0);
    ext_frame(12'h7FE, 1'b1, 1'b0);
    ext_frame(12'hC3A, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) ext_frame(RES_W'($urandom), 1'($urandom), 1'b0);
    chk(!sclk_o, "R2 no internal clock in external mode", sclk_o, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule